// File: doc/BRIEF.md
# Bounded-Latency Request/Completion Monitor

This block is a synthesizable run-time monitor that sits beside a design and watches two single-bit event lines on one clock: a request strobe and a completion strobe. Every accepted request opens its own tracker. A tracker succeeds if a completion arrives within a parameterised window of cycles after the request cycle. It fails if the window closes with no completion. Trackers are kept in age order, so several requests can be in flight at once, each offset in time from the others.

A mode pin chooses how a completion pulse is shared out. In shared mode one pulse closes every tracker whose window is open. In consuming mode a pulse closes only the oldest open tracker. This one-to-one matching means that back-to-back requests each need their own completion. A completion that no open window can accept is ignored by default, and a parameter can turn it into a violation instead. The monitor has no data path, so every pin is a plain level or strobe with no handshake. The window bounds are checked when the design is elaborated: the lower bound must be at least 1 and no greater than the upper bound.

Top module: `req_resp_watch`

## Requirements
- R1: A completion satisfies a tracker only when it arrives between WIN_LO and WIN_HI cycles after the request cycle, with defaults 1 and 10. A completion in the request cycle itself never satisfies that request. `pass_o` is high in the same cycle as an accepted completion.
- R2: Each request accepted while other trackers are pending starts a separate tracker. Its elapsed count begins at the request cycle, and it is judged independently of the older trackers.
- R3: With `mode_i` = 0 (shared), a single completion pulse closes every pending tracker whose window is open, and they all succeed in that cycle.
- R4: With `mode_i` = 1 (consuming), a completion pulse closes only the oldest pending tracker whose window is open. Younger trackers stay pending.
- R5: Take requests in two consecutive cycles, followed by one single-cycle completion inside both windows. In consuming mode, `viol_o` pulses WIN_HI cycles after the second request. In shared mode no violation follows.
- R6: When a tracker reaches WIN_HI elapsed cycles without a completion, `viol_o` is high for exactly that one cycle and the tracker is freed.
- R7: `pending_o` gives the number of trackers in flight. It updates on the clock edge after a request, a success or an expiry.
- R8: If a request arrives when no tracker slot is free, even after the retirements of that cycle, the request is dropped. `overflow_o` then goes high and stays high until reset.
- R9: A completion that no open window accepts has no effect on any output when REPORT_ORPHAN = 0. When REPORT_ORPHAN = 1 it pulses `viol_o` in that cycle.
- R10: Synchronous active-high `rst` empties every tracker and clears `pending_o` and `overflow_o`. While reset is high, `pass_o` and `viol_o` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = shared matching, 1 = consuming matching |
| req_i | input | 1 | Request strobe, one request per high cycle |
| done_i | input | 1 | Completion strobe |
| pass_o | output | 1 | High in a cycle where a completion satisfies at least one tracker |
| viol_o | output | 1 | High in a cycle where a tracker expires or, when enabled, a completion is unsolicited |
| overflow_o | output | 1 | Sticky flag for a request dropped because all trackers were busy |
| pending_o | output | $clog2(DEPTH+1) | Number of trackers in flight |

## Verification
Two kinds of event can fall in the same cycle. The first is a request arriving together with a completion: the completion must go to older trackers and never to the new one. The bench provokes this by pulsing both strobes together, both on an empty monitor and during dense traffic. The second is a request arriving while the oldest tracker retires at a full queue; a small-depth instance is driven with request bursts longer than its depth so this happens often. In every cycle the bench compares the pulses, the count and the flag against a model. The model keeps the request cycle numbers and works out elapsed time by subtraction.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
  typedef enum logic {
    MATCH_SHARED  = 1'b0,
    MATCH_CONSUME = 1'b1
  } match_mode_e;
endpackage

// File: rtl/rrw_queue.sv
// Age-ordered tracker store: entry 0 is the oldest. Retirements always
// form a prefix, so they are removed by shifting the queue down.
module rrw_queue #(
  parameter int DEPTH = 12,
  parameter int HI    = 10,
  parameter int AGE_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [CNT_W-1:0] pop_n_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [AGE_W-1:0] age_o [DEPTH],
  output logic             drop_o
);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(DEPTH);
  localparam logic [AGE_W-1:0] ONE_A = AGE_W'(1);

  logic [AGE_W-1:0] age_q [DEPTH];
  logic [AGE_W-1:0] age_n [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_n, space;
  logic             take;

  always_comb begin
    space  = cnt_q - pop_n_i;
    drop_o = push_i && (space == FULL);
    take   = push_i && !drop_o;
    cnt_n  = space + CNT_W'(take);
    for (int i = 0; i < DEPTH; i++) begin
      age_n[i] = '0;
      for (int j = 0; j < DEPTH; j++) begin
        if ((CNT_W'(j) == CNT_W'(i) + pop_n_i) && (CNT_W'(j) < cnt_q))
          age_n[i] = age_q[j] + ONE_A;
      end
      if (take && (space == CNT_W'(i)))
        age_n[i] = ONE_A;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) age_q[i] <= '0;
    end else begin
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) age_q[i] <= age_n[i];
    end
  end

  assign cnt_o = cnt_q;
  assign age_o = age_q;

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL); // R8
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (rst)
    drop_o |-> (cnt_q == FULL)); // R8
  AST_AGE_CAP: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |-> (age_q[0] <= AGE_W'(HI))); // R6

  for (genvar g = 0; g + 1 < DEPTH; g++) begin : g_order
    AST_AGE_ORDER: assert property (@(posedge clk) disable iff (rst)
      (CNT_W'(g + 1) < cnt_q) |-> (age_q[g] > age_q[g+1])); // R2
  end
endmodule

// File: rtl/rrw_judge.sv
// Decides per cycle which trackers a completion closes, which expires,
// and how many leave the head of the queue.
module rrw_judge
  import rrw_pkg::*;
#(
  parameter int   DEPTH  = 12,
  parameter int   LO     = 1,
  parameter int   HI     = 10,
  parameter int   AGE_W  = 4,
  parameter int   CNT_W  = 4,
  parameter bit   ORPHAN = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  match_mode_e      mode_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [AGE_W-1:0] age_i [DEPTH],
  output logic             pass_o,
  output logic             expire_o,
  output logic             orphan_o,
  output logic [CNT_W-1:0] pop_n_o
);
  localparam logic [AGE_W-1:0] LO_A = AGE_W'(LO);
  localparam logic [AGE_W-1:0] HI_A = AGE_W'(HI);

  logic [DEPTH-1:0] open_w, first_w, hit;

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      open_w[i] = (CNT_W'(i) < cnt_i) && (age_i[i] >= LO_A);
    first_w = open_w & ~(open_w - DEPTH'(1));
    if (!done_i)                    hit = '0;
    else if (mode_i == MATCH_CONSUME) hit = first_w;
    else                            hit = open_w;
    pass_o   = |hit;
    expire_o = (cnt_i != '0) && (age_i[0] == HI_A) && !hit[0];
    orphan_o = ORPHAN && done_i && (open_w == '0);
    pop_n_o  = CNT_W'($countones(hit)) + CNT_W'(expire_o);
  end

  AST_HIT_PREFIX: assert property (@(posedge clk) disable iff (rst)
    ((hit >> 1) & ~hit) == '0); // R3
  AST_CONSUME_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (mode_i == MATCH_CONSUME) |-> $onehot0(hit)); // R4
  AST_EXPIRE_NO_PASS: assert property (@(posedge clk) disable iff (rst)
    !(expire_o && pass_o)); // R6
  AST_ORPHAN_NO_PASS: assert property (@(posedge clk) disable iff (rst)
    !(orphan_o && pass_o)); // R9
endmodule

// File: rtl/req_resp_watch.sv
module req_resp_watch
  import rrw_pkg::*;
#(
  parameter int DEPTH         = 12,
  parameter int WIN_LO        = 1,
  parameter int WIN_HI        = 10,
  parameter bit REPORT_ORPHAN = 1'b0,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AGE_W = $clog2(WIN_HI + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_i,
  input  logic             req_i,
  input  logic             done_i,
  output logic             pass_o,
  output logic             viol_o,
  output logic             overflow_o,
  output logic [CNT_W-1:0] pending_o
);
  if (WIN_LO < 1 || WIN_LO > WIN_HI || DEPTH < 1) begin : g_bad_cfg
    $error("req_resp_watch: window bounds or depth out of range");
  end

  match_mode_e      mode;
  logic [CNT_W-1:0] cnt, pop_n;
  logic [AGE_W-1:0] age [DEPTH];
  logic             drop, expire, orphan, pass_w;
  logic             ovf_q;

  assign mode = match_mode_e'(mode_i);

  rrw_queue #(.DEPTH(DEPTH), .HI(WIN_HI), .AGE_W(AGE_W), .CNT_W(CNT_W)) u_queue (
    .clk(clk), .rst(rst), .push_i(req_i), .pop_n_i(pop_n),
    .cnt_o(cnt), .age_o(age), .drop_o(drop)
  );

  rrw_judge #(.DEPTH(DEPTH), .LO(WIN_LO), .HI(WIN_HI), .AGE_W(AGE_W),
              .CNT_W(CNT_W), .ORPHAN(REPORT_ORPHAN)) u_judge (
    .clk(clk), .rst(rst), .mode_i(mode), .done_i(done_i), .cnt_i(cnt),
    .age_i(age), .pass_o(pass_w), .expire_o(expire), .orphan_o(orphan),
    .pop_n_o(pop_n)
  );

  always_ff @(posedge clk) begin
    if (rst)       ovf_q <= 1'b0;
    else if (drop) ovf_q <= 1'b1;
  end

  assign pass_o     = pass_w && !rst;
  assign viol_o     = (expire || orphan) && !rst;
  assign overflow_o = ovf_q;
  assign pending_o  = cnt;

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o); // R8
  AST_PEND_RISE: assert property (@(posedge clk) disable iff (rst)
    (pending_o > $past(pending_o)) |-> $past(req_i)); // R7
  AST_PEND_STEP: assert property (@(posedge clk) disable iff (rst)
    (pending_o <= $past(pending_o) + CNT_W'(1))); // R2
  AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    viol_o |-> (pending_o != '0 || done_i)); // R6
endmodule

// File: tb/req_resp_watch_test.sv
module rrw_model #(
  parameter int DEPTH = 12,
  parameter int LO    = 1,
  parameter int HI    = 10,
  parameter bit ORPH  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic mode,
  input  logic req,
  input  logic done,
  output logic e_pass,
  output logic e_viol,
  output logic e_ovf,
  output int   e_pend
);
  int stamp [DEPTH];
  int n, cyc;
  bit ovf;

  always @(*) begin
    bit open0;
    open0  = (n > 0) && (cyc - stamp[0] >= LO);
    e_pass = !rst && done && open0;
    e_viol = !rst && (((n > 0) && (cyc - stamp[0] == HI) && !done) ||
                      (ORPH && done && !open0));
    e_ovf  = ovf;
    e_pend = n;
  end

  always @(posedge clk) begin
    if (rst) begin
      n = 0; ovf = 0; cyc = 0;
    end else begin
      int k;
      k = 0;
      if (done && n > 0 && (cyc - stamp[0] >= LO)) begin
        if (mode) k = 1;
        else for (int i = 0; i < n; i++) if (cyc - stamp[i] >= LO) k = k + 1;
      end else if (n > 0 && cyc - stamp[0] == HI) k = 1;
      for (int i = 0; i + k < n; i++) stamp[i] = stamp[i+k];
      n = n - k;
      if (req) begin
        if (n < DEPTH) begin stamp[n] = cyc; n = n + 1; end
        else ovf = 1;
      end
      cyc = cyc + 1;
    end
  end
endmodule

module req_resp_watch_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0, req = 1'b0, done = 1'b0;
  int checks = 0, errors = 0;

  logic       a_pass, a_viol, a_ovf;
  logic [3:0] a_pend;
  logic       b_pass, b_viol, b_ovf;
  logic [2:0] b_pend;
  logic       ea_pass, ea_viol, ea_ovf, eb_pass, eb_viol, eb_ovf;
  int         ea_pend, eb_pend;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  req_resp_watch uut (
    .clk(clk), .rst(rst), .mode_i(mode), .req_i(req), .done_i(done),
    .pass_o(a_pass), .viol_o(a_viol), .overflow_o(a_ovf), .pending_o(a_pend));

  req_resp_watch #(.DEPTH(4), .WIN_LO(2), .WIN_HI(5), .REPORT_ORPHAN(1'b1)) uut_s (
    .clk(clk), .rst(rst), .mode_i(mode), .req_i(req), .done_i(done),
    .pass_o(b_pass), .viol_o(b_viol), .overflow_o(b_ovf), .pending_o(b_pend));

  rrw_model #(.DEPTH(12), .LO(1), .HI(10), .ORPH(1'b0)) m_a (
    .clk(clk), .rst(rst), .mode(mode), .req(req), .done(done),
    .e_pass(ea_pass), .e_viol(ea_viol), .e_ovf(ea_ovf), .e_pend(ea_pend));
  rrw_model #(.DEPTH(4), .LO(2), .HI(5), .ORPH(1'b1)) m_b (
    .clk(clk), .rst(rst), .mode(mode), .req(req), .done(done),
    .e_pass(eb_pass), .e_viol(eb_viol), .e_ovf(eb_ovf), .e_pend(eb_pend));

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, got, exp);
    end
  endtask

  task automatic compare_all();
    chk(a_pass, ea_pass, mode ? "R4 pass(def)" : "R3 pass(def)");
    chk(a_viol, ea_viol, "R6 viol(def)");
    chk(a_ovf,  ea_ovf,  "R8 ovf(def)");
    chk(a_pend, ea_pend, "R7 pend(def)");
    chk(b_pass, eb_pass, mode ? "R4 pass(small)" : "R3 pass(small)");
    chk(b_viol, eb_viol, "R9 viol(small)");
    chk(b_ovf,  eb_ovf,  "R8 ovf(small)");
    chk(b_pend, eb_pend, "R2 pend(small)");
  endtask

  // drive at the falling edge, judge 1 ns before the rising edge
  task automatic tick(input logic r, input logic d);
    @(negedge clk);
    req = r; done = d;
    #3;
    if (!rst) compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; req = 1'b0; done = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    #3;
    chk(a_pass, 0, "R10 pass in reset"); chk(a_viol, 0, "R10 viol in reset");
    chk(a_pend, 0, "R10 pend"); chk(a_ovf, 0, "R10 ovf");
    @(negedge clk); rst = 1'b0;

    // R5 consuming: req at c0,c1, done at c3, violation at c1+10
    mode = 1'b1;
    tick(1, 0); tick(1, 0); tick(0, 0);
    tick(0, 1); chk(a_pass, 1, "R5 consume pass");
    chk(a_pend, 2, "R7 two pending");
    for (int c = 4; c <= 11; c++) begin
      tick(0, 0);
      chk(a_viol, (c == 11) ? 1 : 0, "R5 consume second request expires");
    end
    tick(0, 0); chk(a_pend, 0, "R6 freed after expiry");

    // R5 shared: same pattern, no violation
    do_reset(); mode = 1'b0;
    tick(1, 0); tick(1, 0); tick(0, 0);
    tick(0, 1); chk(a_pass, 1, "R5 shared pass");
    for (int c = 4; c <= 12; c++) begin
      tick(0, 0);
      chk(a_viol, 0, "R5 shared no violation");
      chk(a_pend, 0, "R3 both closed");
    end

    // R1 window sweep on default instance, both modes
    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d <= 12; d++) begin
        do_reset(); mode = m[0];
        tick(1, d == 0);
        chk(a_pass, 0, "R1 same cycle never counts");
        chk(a_viol, 0, "R9 ignored unsolicited");
        for (int c = 1; c <= 12; c++) begin
          tick(0, c == d);
          chk(a_pass, (c == d && d <= 10) ? 1 : 0, "R1 window pass");
          chk(a_viol, (c == 10 && (d == 0 || d > 10)) ? 1 : 0, "R6 expiry");
        end
      end
    end

    // R9: unsolicited completion on empty monitors
    do_reset();
    tick(0, 1);
    chk(a_viol, 0, "R9 ignored by default"); chk(a_pend, 0, "R9 pend untouched");
    chk(b_viol, 1, "R9 reported when enabled");

    // model sweep: density x mode
    for (int m = 0; m < 2; m++) begin
      for (int dens = 1; dens <= 4; dens++) begin
        do_reset(); mode = m[0];
        for (int c = 0; c < 400; c++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          tick(lfsr[3:0] < 4'(dens * 3), lfsr[7:4] < 4'(dens * 3));
          if (c == 200) mode = ~mode;
        end
      end
    end

    // R8 and R10: burst overflows small instance, reset clears it
    do_reset(); mode = 1'b1;
    for (int c = 0; c < 6; c++) tick(1, 0);
    chk(b_ovf, 1, "R8 overflow raised");
    for (int c = 0; c < 8; c++) tick(0, 0);
    chk(b_ovf, 1, "R8 overflow sticky");
    do_reset(); #3;
    chk(b_ovf, 0, "R10 overflow cleared"); chk(b_pend, 0, "R10 pend cleared");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule